// File: doc/BRIEF.md
# Pipelined SIMD Packed Multiply-Add Unit

This block is a lockstep vector arithmetic pipeline. It treats each 128-bit operand word as a row of equal-width integer lanes, and every lane runs the same operation in the same cycle. Two operations are supported. The first is an element-wise signed multiply. The second is a three-operand multiply-add that computes `a*b+c` in each lane. The lane width is picked per operation: sixteen 8-bit lanes, four 32-bit lanes or two 64-bit lanes.

A new operation may be issued on every cycle, with no bubbles. Consecutive operations may use different lane widths. Each result comes out a fixed six cycles after issue.

A small control/status register decides what happens when a lane's exact result does not fit its width. It holds one mask bit and one sticky overflow flag for each lane width.
- When the mask bit is set, execution continues and each overflowing lane is replaced by its saturated limit.
- When the mask bit is clear, the result is passed on wrapped and a one-cycle trap pulse marks it.

Top module: `simd_mac_unit`

## Requirements
- R1: `in_mode` selects the lane partition: 0 gives sixteen 8-bit lanes, 1 gives four 32-bit lanes, and 2 or 3 give two 64-bit lanes. Lane i occupies bits [i*W +: W], and lanes never affect one another.
- R2: With `in_op`=0, each lane returns the low W bits of the signed two's-complement product a*b.
- R3: With `in_op`=1, each lane returns the low W bits of the exact signed value a*b+c, where c uses the same lane width.
- R4: An operation sampled with `in_valid` high at a rising edge shows `out_valid` high exactly six rising edges later. Issue is accepted on every cycle, and `out_valid` is never high without a matching issue.
- R5: Operations of different lane widths and opcodes may follow each other on consecutive cycles. Each one is computed with its own width and opcode.
- R6: A lane overflows when its exact signed result (product, or product plus addend) lies outside [-2^(W-1), 2^(W-1)-1].
- R7: When the mask bit for the result's width is 1 at the cycle the result leaves, every overflowing lane is replaced by 2^(W-1)-1 if the exact result is positive, or by -2^(W-1) if it is negative. Other lanes are unchanged and `out_trap` stays low.
- R8: When that mask bit is 0 and any lane overflows, `out_trap` is high for exactly the result's `out_valid` cycle, and every lane carries its wrapped low W bits.
- R9: `csr_rdata`/`csr_wdata` use bits [2:0] for the sticky overflow flags and bits [5:3] for the mask bits. Bit 0/3 is the 8-bit width, bit 1/4 the 32-bit width, and bit 2/5 the 64-bit width. A valid result with any overflowing lane sets its width's flag at the following edge. A flag is cleared only by a write with `csr_we`. When a write and a set land on the same edge, the set wins.
- R10: After reset, `out_valid` and `out_trap` are low, all flags are 0 and all mask bits are 1 (`csr_rdata` = 6'b111000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Issue an operation this cycle |
| in_op | input | 1 | 0 = multiply, 1 = multiply-add |
| in_mode | input | 2 | Lane width selector |
| in_a | input | 128 | Multiplicand word |
| in_b | input | 128 | Multiplier word |
| in_c | input | 128 | Addend word (multiply-add only) |
| out_valid | output | 1 | Result word valid |
| out_data | output | 128 | Result word |
| out_trap | output | 1 | Unmasked overflow on this result |
| csr_we | input | 1 | Write the control/status register |
| csr_wdata | input | 6 | Write value: masks [5:3], flags [2:0] |
| csr_rdata | output | 6 | Current masks [5:3] and flags [2:0] |

## Verification
The 8-bit partition is swept over every pair of signed lane values, both for plain multiply and for multiply-add with a varying addend. This separates wrapped low bits from saturation on both signs, and it exposes any lane that picks up its neighbour's bits.

The 32-bit and 64-bit partitions are tried with limit values (most negative times minus one, maximum squared, and an overflow caused only by the addend) together with random words. Random back-to-back sequences that mix widths and opcodes show whether width and opcode follow each operation down the pipe. The same overflowing operands are then rerun with masks cleared, and after flag writes, to tell trapping from saturating and sticky flags from transient ones.

// File: rtl/simd_mac_pkg.sv
package simd_mac_pkg;
    localparam int DATA_W  = 128;
    localparam int NWIDTHS = 3;

    typedef enum logic [1:0] {
        LM_B8  = 2'd0,
        LM_W32 = 2'd1,
        LM_D64 = 2'd2,
        LM_D64B = 2'd3
    } lane_mode_e;

    typedef struct packed {
        logic               valid;
        logic               fma;
        lane_mode_e         mode;
        logic [DATA_W-1:0]  a;
        logic [DATA_W-1:0]  b;
        logic [DATA_W-1:0]  c;
    } issue_t;

    typedef struct packed {
        logic               valid;
        lane_mode_e         mode;
        logic               ovf;
        logic [DATA_W-1:0]  wrap;
        logic [DATA_W-1:0]  sat;
    } res_t;

    function automatic logic [1:0] width_idx(lane_mode_e m);
        return (m == LM_D64B) ? 2'd2 : 2'(m);
    endfunction
endpackage

// File: rtl/simd_mac_lane.sv
module simd_mac_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    input  logic         fma,
    output logic [W-1:0] wrap,
    output logic [W-1:0] sat_val,
    output logic         ovf
);
    logic signed [2*W-1:0] prod;
    logic signed [2*W:0]   exact;
    logic [W+1:0]          top_bits;

    always_comb begin
        prod  = $signed({{W{a[W-1]}}, a}) * $signed({{W{b[W-1]}}, b});
        exact = {prod[2*W-1], prod} + (fma ? {{(W+1){c[W-1]}}, c} : '0);
        top_bits = exact[2*W:W-1];
        ovf   = !((&top_bits) || !(|top_bits));
        wrap  = exact[W-1:0];
        if (!ovf)
            sat_val = wrap;
        else if (exact[2*W])
            sat_val = {1'b1, {(W-1){1'b0}}};
        else
            sat_val = {1'b0, {(W-1){1'b1}}};
    end
endmodule

// File: rtl/simd_mac_word.sv
module simd_mac_word #(
    parameter int LW = 8,
    parameter int DW = 128
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [DW-1:0] c,
    input  logic          fma,
    output logic [DW-1:0] wrap,
    output logic [DW-1:0] sat,
    output logic          ovf_any
);
    localparam int NL = DW / LW;
    logic [NL-1:0] lane_ovf;

    for (genvar g = 0; g < NL; g++) begin : g_lane
        simd_mac_lane #(.W(LW)) u_lane (
            .a       (a[g*LW +: LW]),
            .b       (b[g*LW +: LW]),
            .c       (c[g*LW +: LW]),
            .fma     (fma),
            .wrap    (wrap[g*LW +: LW]),
            .sat_val (sat[g*LW +: LW]),
            .ovf     (lane_ovf[g])
        );
    end

    assign ovf_any = |lane_ovf;
endmodule

// File: rtl/simd_mac_csr.sv
module simd_mac_csr #(
    parameter int NW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [2*NW-1:0] wdata,
    input  logic [NW-1:0]   set,
    output logic [NW-1:0]   masks,
    output logic [NW-1:0]   flags,
    output logic [2*NW-1:0] rdata
);
    typedef struct packed {
        logic [NW-1:0] mask;
        logic [NW-1:0] flag;
    } csr_t;

    csr_t csr_d, csr_q;

    always_comb begin
        csr_d = csr_q;
        if (we) begin
            csr_d.mask = wdata[2*NW-1:NW];
            csr_d.flag = wdata[NW-1:0];
        end
        csr_d.flag = csr_d.flag | set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csr_q.mask <= '1;
            csr_q.flag <= '0;
        end else begin
            csr_q <= csr_d;
        end
    end

    assign masks = csr_q.mask;
    assign flags = csr_q.flag;
    assign rdata = {csr_q.mask, csr_q.flag};

    for (genvar i = 0; i < NW; i++) begin : g_chk
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (!we && flags[i]) |=> flags[i]); // R9
        AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> flags[i]); // R9
    end
endmodule

// File: rtl/simd_mac_unit.sv
module simd_mac_unit
    import simd_mac_pkg::*;
#(
    parameter int LATENCY = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_op,
    input  logic [1:0]        in_mode,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    input  logic [DATA_W-1:0] in_c,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_trap,
    input  logic              csr_we,
    input  logic [2*NWIDTHS-1:0] csr_wdata,
    output logic [2*NWIDTHS-1:0] csr_rdata
);
    localparam int NRES = LATENCY - 1;

    issue_t s1_d, s1_q;
    res_t   stg_d [NRES];
    res_t   stg_q [NRES];

    logic [DATA_W-1:0] w8_wrap, w8_sat, w32_wrap, w32_sat, w64_wrap, w64_sat;
    logic              w8_ovf, w32_ovf, w64_ovf;
    logic [NWIDTHS-1:0] masks, flags, flag_set;
    logic [1:0]         out_idx;
    logic               out_masked;

    simd_mac_word #(.LW(8), .DW(DATA_W)) u_w8 (
        .a(s1_q.a), .b(s1_q.b), .c(s1_q.c), .fma(s1_q.fma),
        .wrap(w8_wrap), .sat(w8_sat), .ovf_any(w8_ovf));
    simd_mac_word #(.LW(32), .DW(DATA_W)) u_w32 (
        .a(s1_q.a), .b(s1_q.b), .c(s1_q.c), .fma(s1_q.fma),
        .wrap(w32_wrap), .sat(w32_sat), .ovf_any(w32_ovf));
    simd_mac_word #(.LW(64), .DW(DATA_W)) u_w64 (
        .a(s1_q.a), .b(s1_q.b), .c(s1_q.c), .fma(s1_q.fma),
        .wrap(w64_wrap), .sat(w64_sat), .ovf_any(w64_ovf));

    always_comb begin
        s1_d.valid = in_valid;
        s1_d.fma   = in_op;
        s1_d.mode  = lane_mode_e'(in_mode);
        s1_d.a     = in_a;
        s1_d.b     = in_b;
        s1_d.c     = in_c;

        stg_d[0].valid = s1_q.valid;
        stg_d[0].mode  = s1_q.mode;
        case (s1_q.mode)
            LM_B8: begin
                stg_d[0].ovf = w8_ovf;  stg_d[0].wrap = w8_wrap;  stg_d[0].sat = w8_sat;
            end
            LM_W32: begin
                stg_d[0].ovf = w32_ovf; stg_d[0].wrap = w32_wrap; stg_d[0].sat = w32_sat;
            end
            default: begin
                stg_d[0].ovf = w64_ovf; stg_d[0].wrap = w64_wrap; stg_d[0].sat = w64_sat;
            end
        endcase
        for (int i = 1; i < NRES; i++)
            stg_d[i] = stg_q[i-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            for (int i = 0; i < NRES; i++)
                stg_q[i] <= '0;
        end else begin
            s1_q <= s1_d;
            for (int i = 0; i < NRES; i++)
                stg_q[i] <= stg_d[i];
        end
    end

    always_comb begin
        out_idx    = width_idx(stg_q[NRES-1].mode);
        out_masked = masks[out_idx];
        out_valid  = stg_q[NRES-1].valid;
        out_data   = out_masked ? stg_q[NRES-1].sat : stg_q[NRES-1].wrap;
        out_trap   = out_valid && stg_q[NRES-1].ovf && !out_masked;
        flag_set   = '0;
        if (out_valid && stg_q[NRES-1].ovf)
            flag_set[out_idx] = 1'b1;
    end

    simd_mac_csr #(.NW(NWIDTHS)) u_csr (
        .clk(clk), .rst_n(rst_n), .we(csr_we), .wdata(csr_wdata),
        .set(flag_set), .masks(masks), .flags(flags), .rdata(csr_rdata));

    AST_TRAP_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_trap |-> out_valid); // R8
    AST_TRAP_ONLY_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        out_trap |-> (csr_rdata[NWIDTHS +: NWIDTHS] != '1)); // R7
    AST_TRAP_RAISES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        out_trap |=> (csr_rdata[NWIDTHS-1:0] != '0)); // R9
    AST_RESULT_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$isunknown(out_data)); // R4
    AST_VALID_FROM_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        stg_q[0].valid |-> $past(s1_q.valid)); // R4
endmodule

// File: tb/simd_mac_unit_test.sv
module simd_mac_unit_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0, in_op = 1'b0;
    logic [1:0]   in_mode = 2'd0;
    logic [127:0] in_a = '0, in_b = '0, in_c = '0;
    logic         out_valid, out_trap;
    logic [127:0] out_data;
    logic         csr_we = 1'b0;
    logic [5:0]   csr_wdata = '0;
    logic [5:0]   csr_rdata;

    always #2 clk = ~clk;

    simd_mac_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_mode(in_mode), .in_a(in_a), .in_b(in_b), .in_c(in_c),
        .out_valid(out_valid), .out_data(out_data), .out_trap(out_trap),
        .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata));

    int checks = 0, fails = 0, cyc = 0;
    bit           ev[8];
    bit           eovf[8];
    int           emi[8];
    logic [127:0] ewrap[8], esat[8];
    string        etag[8];
    logic [2:0]   mmask = 3'b111, mflag = 3'b000;

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s cycle %0d actual %h expected %h", tag, cyc, act, exp);
        end
    endtask

    function automatic void lane_ref(int w, logic [63:0] a, logic [63:0] b, logic [63:0] c,
                                     bit fma, output logic [63:0] wr, output logic [63:0] st,
                                     output bit ovf);
        logic signed [131:0] sa, sb, sc, p, mx, mn;
        logic [63:0] m;
        for (int i = 0; i < 132; i++) begin
            sa[i] = (i < w) ? a[i] : a[w-1];
            sb[i] = (i < w) ? b[i] : b[w-1];
            sc[i] = (i < w) ? c[i] : c[w-1];
        end
        p  = sa * sb;
        if (fma) p = p + sc;
        mx = (132'sd1 <<< (w - 1)) - 132'sd1;
        mn = -mx - 132'sd1;
        m  = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        ovf = (p > mx) || (p < mn);
        wr = p[63:0] & m;
        st = ovf ? ((p < 0) ? (mn[63:0] & m) : (mx[63:0] & m)) : wr;
    endfunction

    task automatic step(bit v, bit op, logic [1:0] md, logic [127:0] a, logic [127:0] b,
                        logic [127:0] c, string tag, bit we = 1'b0, logic [5:0] wd = '0);
        int k, s, w;
        logic [127:0] expd;
        logic [2:0] setv;
        logic [63:0] lw, ls;
        bit lo;
        @(negedge clk);
        k = (cyc + 2) % 8;
        chk("R4 valid", 128'(out_valid), 128'(ev[k]));
        if (ev[k]) begin
            expd = mmask[emi[k]] ? esat[k] : ewrap[k];
            chk(etag[k], out_data, expd);
            chk("R8 trap", 128'(out_trap), 128'(eovf[k] && !mmask[emi[k]]));
        end else begin
            chk("R8 trap idle", 128'(out_trap), 128'(0));
        end
        chk("R9 csr", 128'(csr_rdata), 128'({mmask, mflag}));
        setv = (ev[k] && eovf[k]) ? (3'b001 << emi[k]) : 3'b000;
        if (we) begin
            mmask = wd[5:3];
            mflag = wd[2:0];
        end
        mflag = mflag | setv;
        in_valid = v; in_op = op; in_mode = md; in_a = a; in_b = b; in_c = c;
        csr_we = we; csr_wdata = wd;
        s = cyc % 8;
        ev[s] = v;
        etag[s] = tag;
        emi[s] = (md == 2'd3) ? 2 : int'(md);
        w = (md == 2'd0) ? 8 : (md == 2'd1) ? 32 : 64;
        ewrap[s] = '0; esat[s] = '0; eovf[s] = 1'b0;
        for (int l = 0; l < 128 / w; l++) begin
            lane_ref(w, 64'(a >> (l * w)), 64'(b >> (l * w)), 64'(c >> (l * w)), op, lw, ls, lo);
            ewrap[s] |= 128'(lw) << (l * w);
            esat[s]  |= 128'(ls) << (l * w);
            eovf[s]  |= lo;
        end
        cyc++;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 2'd0, '0, '0, '0, "R4 idle");
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        logic [127:0] a, b, c;
        localparam logic [63:0] MAX64 = 64'h7fff_ffff_ffff_ffff;
        localparam logic [63:0] MIN64 = 64'h8000_0000_0000_0000;
        repeat (3) @(negedge clk);
        chk("R10 valid", 128'(out_valid), 128'(0));
        chk("R10 trap", 128'(out_trap), 128'(0));
        chk("R10 csr", 128'(csr_rdata), 128'(6'b111000));
        rst_n = 1'b1;

        // R2 / R7: every signed 8-bit pair, multiply, saturating
        for (int av = 0; av < 256; av++)
            for (int bb = 0; bb < 16; bb++) begin
                for (int l = 0; l < 16; l++) begin
                    a[l*8 +: 8] = 8'(av);
                    b[l*8 +: 8] = 8'(bb * 16 + l);
                end
                step(1'b1, 1'b0, 2'd0, a, b, '0, "R2 mul8 sat R7");
            end
        // R3 / R6: every pair again, multiply-add with varying addend
        for (int av = 0; av < 256; av++)
            for (int bb = 0; bb < 16; bb++) begin
                for (int l = 0; l < 16; l++) begin
                    a[l*8 +: 8] = 8'(av);
                    b[l*8 +: 8] = 8'(bb * 16 + l);
                    c[l*8 +: 8] = 8'(av * 7 + bb * 13 + l * 29);
                end
                step(1'b1, 1'b1, 2'd0, a, b, c, "R3 fma8 R6");
            end
        // R1 / R6: wide-lane limits
        step(1'b1, 1'b0, 2'd2, {MIN64, MAX64}, {64'hffff_ffff_ffff_ffff, MAX64}, '0, "R6 mul64 limits");
        step(1'b1, 1'b1, 2'd2, {MAX64, MIN64}, {64'd1, 64'd1}, {64'd1, 64'hffff_ffff_ffff_ffff}, "R6 fma64 addend ovf");
        step(1'b1, 1'b1, 2'd3, {MAX64, 64'd5}, {64'd1, 64'd7}, {64'd0, 64'd9}, "R1 mode3 as 64");
        step(1'b1, 1'b0, 2'd1, {32'h8000_0000, 32'h7fff_ffff, 32'hffff_ffff, 32'd3},
             {32'hffff_ffff, 32'd2, 32'h8000_0000, 32'd5}, '0, "R6 mul32 limits");
        step(1'b1, 1'b1, 2'd1, {4{32'h7fff_ffff}}, {4{32'd1}},
             {32'd1, 32'hffff_ffff, 32'h8000_0000, 32'd0}, "R6 fma32 addend");
        for (int i = 0; i < 300; i++)
            step(1'b1, 1'(i), 2'd1, rnd128(), rnd128(), rnd128(), "R1 w32 random");
        for (int i = 0; i < 300; i++)
            step(1'b1, 1'(i), 2'd2, rnd128(), rnd128(), rnd128(), "R1 w64 random");
        // R5: interleaved widths and opcodes, with gaps
        for (int i = 0; i < 600; i++)
            step(($urandom % 5) != 0, 1'($urandom), 2'($urandom), rnd128(), rnd128(), rnd128(), "R5 mixed");
        idle(8);
        // R9: clear flags by write, keep masks
        step(1'b0, 1'b0, 2'd0, '0, '0, '0, "R9 clear", 1'b1, 6'b111000);
        idle(3);
        // R8: trap mode on all widths
        step(1'b0, 1'b0, 2'd0, '0, '0, '0, "R8 unmask", 1'b1, 6'b000000);
        for (int i = 0; i < 400; i++)
            step(1'b1, 1'($urandom), 2'($urandom), rnd128(), rnd128(), rnd128(), "R8 trap wrap");
        idle(8);
        // R7 / R8: only 32-bit masked
        step(1'b0, 1'b0, 2'd0, '0, '0, '0, "R7 mixed masks", 1'b1, 6'b010000);
        for (int i = 0; i < 300; i++)
            step(1'b1, 1'($urandom), 2'($urandom), rnd128(), rnd128(), rnd128(), "R7 partial mask");
        // R9: write landing together with a set; set wins
        for (int i = 0; i < 40; i++)
            step(1'b1, 1'b0, 2'd0, {16{8'h7f}}, {16{8'h7f}}, '0, "R9 write vs set",
                 (i % 3) == 0, 6'b010000);
        idle(10);
        chk("R9 flags sticky idle", 128'(csr_rdata), 128'({mmask, mflag}));
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R4 watchdog expired actual running expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule